// File: doc/BRIEF.md
# Sticky Out-of-Limit Status Register

This block collects out-of-limit indications from a set of monitored channels (voltages and temperatures) into one read-only status byte. Each channel provides a live "above high limit" flag and a live "below low limit" flag. When either flag is seen, the channel's event bit is latched and stays set after the condition goes away. Software reading the status byte clears only those event bits whose channel is back within limits. A bit whose channel is still out of limits at the moment of the read stays set.

The top bit of the byte is not latched. It is a live summary: the OR of every bit of a second status register that lives elsewhere. Software can test that one bit and skip reading the second register when it is zero. The channel in bit 0 can be switched to a thermal-timer source through a shared-pin mode input. In that mode bit 0 tracks a "timer limit exceeded" flag in place of its own limit flags.

An interrupt request is raised while any bit of the byte is 1. The limit comparators, the timer and the second status register are outside this block. Only their resulting flags arrive here.

Top module: `oolstat_reg`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every event bit (`status[6:0]`) is 0 and `rd_data` is 0x00; with `aux_stat` all zero the whole byte reads 0x00 and `irq` is 0.
- R2: Event bit i (bit 0 = 2.5 V rail, 1 = processor core rail, 2 = supply rail, 3 = 5 V rail, 4 = remote sensor 1, 5 = local sensor, 6 = remote sensor 2) is 1 in the cycle after `lim_hi[i]` or `lim_lo[i]` is sampled high.
- R3: Without a status read, an event bit that is 1 stays 1 after its flags drop.
- R4: A read is a cycle with `rd_en` = 1 and `rd_addr` equal to the parameter `STAT_ADDR` (default 0x10). After a read, each event bit equals the live condition of its channel in the read cycle, so bits whose condition has gone away are cleared.
- R5: A channel whose condition is asserted in the same cycle as a read keeps its event bit at 1.
- R6: One cycle after a read, `rd_data` holds the full status byte as it stood in the read cycle, before any clear.
- R7: `status[7]` equals the OR of all bits of `aux_stat` in the same cycle. It is never latched and a read does not affect it.
- R8: With `timer_mode` = 1, bit 0 sets from `timer_over` and ignores `lim_hi[0]`/`lim_lo[0]`. With `timer_mode` = 0, `timer_over` has no effect.
- R9: `irq` is 1 exactly when any bit of `status` is 1.
- R10: A cycle with `rd_en` = 1 and any other address clears nothing and loads `rd_data` with 0x00. With `rd_en` = 0, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lim_hi | input | 7 | Live above-high-limit flag per channel |
| lim_lo | input | 7 | Live below-low-limit flag per channel |
| timer_mode | input | 1 | Shared pin in thermal-timer mode; re-sources bit 0 |
| timer_over | input | 1 | Thermal timer limit exceeded |
| aux_stat | input | 8 | Contents of the second status register |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 8 | Registered read data |
| status | output | 8 | Current status byte |
| irq | output | 1 | Interrupt request, any status bit set |

## Verification
The hardest case to reach is a read that lands while some channels are still out of limits and others have recovered. Getting there needs a chosen set of latched bits and a different chosen set of live conditions on the same edge as the read strobe. The bench first latches one 7-bit pattern through a mix of high and low flags and drops the flags. It then presents a second pattern on the read cycle itself, sweeping all first patterns against a spread of second patterns. For each pair it checks that the read returns the first pattern and that the surviving bits equal the second.

// File: rtl/oolstat_pkg.sv
// Package: shared types for the sticky out-of-limit status register.
// Assumes: nothing beyond standard SystemVerilog.
package oolstat_pkg;

    // Source that drives one event channel's condition.
    typedef enum logic {
        SRC_LIMITS = 1'b0,   // OR of the high and low limit flags
        SRC_TIMER  = 1'b1    // thermal timer limit exceeded
    } evt_src_e;

    // Picks the source of a channel that can be re-purposed for the timer.
    function automatic evt_src_e pick_src(input logic timer_mode_i);
        return timer_mode_i ? SRC_TIMER : SRC_LIMITS;
    endfunction

endpackage

// File: rtl/oolstat_cond.sv
// Module: oolstat_cond
// Forms the live out-of-limit condition of every channel: high OR low flag.
// One channel (TIMER_CH) can instead follow the thermal timer flag when the
// shared pin is in timer mode.
// Assumes: all flag inputs are synchronous to clk.
module oolstat_cond
    import oolstat_pkg::*;
#(
    parameter int EVT_N    = 7,
    parameter int TIMER_CH = 0
) (
    input  logic [EVT_N-1:0] lim_hi,
    input  logic [EVT_N-1:0] lim_lo,
    input  logic             timer_mode,
    input  logic             timer_over,
    output logic [EVT_N-1:0] cond
);

    for (genvar ch = 0; ch < EVT_N; ch++) begin : g_ch
        if (ch == TIMER_CH) begin : g_mux
            evt_src_e src;
            // Select the timer flag or the limit flags for this channel.
            always_comb begin
                src = pick_src(timer_mode);
                case (src)
                    SRC_TIMER:  cond[ch] = timer_over;
                    default:    cond[ch] = lim_hi[ch] | lim_lo[ch];
                endcase
            end
        end else begin : g_plain
            // Either limit exceeded raises the condition.
            assign cond[ch] = lim_hi[ch] | lim_lo[ch];
        end
    end

endmodule

// File: rtl/oolstat_cell.sv
// Module: oolstat_cell
// One sticky event bit. Sets on its live condition; a clear request drops it
// only when the condition is absent in the same cycle (set wins).
// Assumes: synchronous active-low reset.
module oolstat_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic clr_req,
    output logic q
);

    // Latch the event; release it only on a clear with no live condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else begin
            q <= cond | (q & ~clr_req);
        end
    end

endmodule

// File: rtl/oolstat_rdport.sv
// Module: oolstat_rdport
// Decodes the host read address and registers the status byte seen in the
// read cycle, so the returned value precedes any clear caused by the read.
// Assumes: one read strobe per cycle at most; synchronous active-low reset.
module oolstat_rdport #(
    parameter int            ADDR_W    = 8,
    parameter int            STAT_W    = 8,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [STAT_W-1:0] status_in,
    output logic              rd_hit,
    output logic [STAT_W-1:0] rd_data
);

    // A read addressed to this register.
    assign rd_hit = rd_en && (rd_addr == STAT_ADDR);

    // Capture pre-clear status on a hit; return zero for other addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_hit ? status_in : '0;
        end
    end

endmodule

// File: rtl/oolstat_reg.sv
// Module: oolstat_reg (top)
// Sticky out-of-limit status byte: EVT_N latched event bits below one live
// summary bit (OR of a second status register), a clear-on-read rule that
// keeps bits whose condition persists, and an interrupt on any set bit.
// Assumes: flags synchronous to clk; synchronous active-low reset.
module oolstat_reg #(
    parameter int            EVT_N     = 7,
    parameter int            AUX_W     = 8,
    parameter int            ADDR_W    = 8,
    parameter int            TIMER_CH  = 0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_N-1:0]   lim_hi,
    input  logic [EVT_N-1:0]   lim_lo,
    input  logic               timer_mode,
    input  logic               timer_over,
    input  logic [AUX_W-1:0]   aux_stat,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [EVT_N:0]     rd_data,
    output logic [EVT_N:0]     status,
    output logic               irq
);

    localparam int STAT_W = EVT_N + 1;

    logic [EVT_N-1:0] cond;
    logic [EVT_N-1:0] evt_q;
    logic             rd_hit;
    logic             aux_any;

    // Live per-channel conditions.
    oolstat_cond #(
        .EVT_N    (EVT_N),
        .TIMER_CH (TIMER_CH)
    ) u_cond (
        .lim_hi     (lim_hi),
        .lim_lo     (lim_lo),
        .timer_mode (timer_mode),
        .timer_over (timer_over),
        .cond       (cond)
    );

    // One sticky bit per channel.
    for (genvar ch = 0; ch < EVT_N; ch++) begin : g_cell
        oolstat_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .cond    (cond[ch]),
            .clr_req (rd_hit),
            .q       (evt_q[ch])
        );
    end

    // Summary of the second status register, live and unlatched.
    assign aux_any = |aux_stat;

    // Assemble the visible status byte.
    assign status = {aux_any, evt_q};

    // Interrupt while anything is flagged.
    assign irq = |status;

    // Host read path.
    oolstat_rdport #(
        .ADDR_W    (ADDR_W),
        .STAT_W    (STAT_W),
        .STAT_ADDR (STAT_ADDR)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .status_in (status),
        .rd_hit    (rd_hit),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/oolstat_reg_chk.sv
// Module: oolstat_reg_chk
// Protocol checker for oolstat_reg, bound to it below. Observes ports only.
module oolstat_reg_chk #(
    parameter int            EVT_N     = 7,
    parameter int            AUX_W     = 8,
    parameter int            ADDR_W    = 8,
    parameter int            TIMER_CH  = 0,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [EVT_N-1:0]   lim_hi,
    input logic [EVT_N-1:0]   lim_lo,
    input logic               timer_mode,
    input logic               timer_over,
    input logic [AUX_W-1:0]   aux_stat,
    input logic               rd_en,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [EVT_N:0]     rd_data,
    input logic [EVT_N:0]     status,
    input logic               irq
);

    logic [EVT_N-1:0] want;
    logic             hit;

    // Expected live conditions seen from the ports.
    always_comb begin
        want = lim_hi | lim_lo;
        if (timer_mode) want[TIMER_CH] = timer_over;
    end

    assign hit = rd_en && (rd_addr == STAT_ADDR);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (status[EVT_N-1:0] == '0 && rd_data == '0));

    // R2
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status[EVT_N-1:0] & $past(want)) == $past(want)));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ((status[EVT_N-1:0] & $past(status[EVT_N-1:0])) == $past(status[EVT_N-1:0])));

    // R4
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (status[EVT_N-1:0] == $past(want)));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && want != '0) |=> ((status[EVT_N-1:0] & $past(want)) != '0));

    // R6
    pre_clear_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (rd_data == $past(status)));

    // R7
    summary_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[EVT_N] == (|aux_stat));

    // R9
    irq_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|status));

    // R10
    miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rd_data == '0));

endmodule

bind oolstat_reg oolstat_reg_chk #(
    .EVT_N     (EVT_N),
    .AUX_W     (AUX_W),
    .ADDR_W    (ADDR_W),
    .TIMER_CH  (TIMER_CH),
    .STAT_ADDR (STAT_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lim_hi     (lim_hi),
    .lim_lo     (lim_lo),
    .timer_mode (timer_mode),
    .timer_over (timer_over),
    .aux_stat   (aux_stat),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .status     (status),
    .irq        (irq)
);

// File: tb/sim_oolstat_reg.sv
// Bench for oolstat_reg: sweeps latched/live pattern pairs through reads,
// all second-register values, the timer mode and stray-address reads.
module sim_oolstat_reg;

    localparam logic [7:0] HIT = 8'h10;
    localparam logic [7:0] MISS = 8'h11;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] lim_hi = '0;
    logic [6:0] lim_lo = '0;
    logic       timer_mode = 1'b0;
    logic       timer_over = 1'b0;
    logic [7:0] aux_stat = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [7:0] status;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    oolstat_reg u0 (
        .clk(clk), .rst_n(rst_n), .lim_hi(lim_hi), .lim_lo(lim_lo),
        .timer_mode(timer_mode), .timer_over(timer_over), .aux_stat(aux_stat),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .status(status), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #(150000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=00 expected=01");
        finish_run();
    end

    initial begin
        // R1: reset state.
        step();
        step();
        check(status == 8'h00, "R1 status", status, 8'h00);
        check(rd_data == 8'h00, "R1 rd_data", rd_data, 8'h00);
        check(irq == 1'b0, "R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        step();
        check(status == 8'h00, "R1 status after release", status, 8'h00);

        // R2 R3 R4 R5 R6 R9: latched pattern a, live pattern b at read.
        for (int a = 0; a < 128; a++) begin
            for (int b = 0; b < 128; b += 9) begin
                logic [6:0] pa;
                logic [6:0] pb;
                pa = 7'(a);
                pb = 7'(b);
                lim_hi = '0; lim_lo = '0; rd_en = 1'b1; rd_addr = HIT;
                step();
                rd_en = 1'b0;
                lim_hi = pa & 7'h55;
                lim_lo = pa & 7'h2A;
                step();
                lim_hi = '0; lim_lo = '0;
                step();
                check(status == {1'b0, pa}, "R2 R3 latched", status, {1'b0, pa});
                check(irq == (pa != 0), "R9 irq", {7'd0, irq}, {7'd0, pa != 0});
                lim_lo = pb; rd_en = 1'b1; rd_addr = HIT;
                step();
                rd_en = 1'b0; lim_lo = '0;
                check(rd_data == {1'b0, pa}, "R6 pre-clear data", rd_data, {1'b0, pa});
                check(status == {1'b0, pb}, "R4 R5 after read", status, {1'b0, pb});
            end
        end

        // R7 R9: summary bit follows the second register, unlatched.
        lim_lo = '0; rd_en = 1'b1; rd_addr = HIT;
        step();
        rd_en = 1'b0;
        for (int v = 0; v < 256; v++) begin
            aux_stat = 8'(v);
            #1;
            check(status == {(v != 0), 7'd0}, "R7 summary", status, {(v != 0), 7'd0});
            check(irq == (v != 0), "R9 irq summary", {7'd0, irq}, {7'd0, v != 0});
            step();
        end
        aux_stat = 8'h04;
        rd_en = 1'b1; rd_addr = HIT;
        step();
        rd_en = 1'b0;
        check(status == 8'h80, "R7 read keeps summary", status, 8'h80);
        check(rd_data == 8'h80, "R7 R6 summary read", rd_data, 8'h80);
        aux_stat = 8'h00;
        #1;
        check(status == 8'h00, "R7 summary drops", status, 8'h00);

        // R8: timer mode re-sources bit 0.
        timer_mode = 1'b1; lim_hi = 7'h01; lim_lo = 7'h01;
        step();
        step();
        check(status == 8'h00, "R8 limits ignored in timer mode", status, 8'h00);
        lim_hi = '0; lim_lo = '0; timer_over = 1'b1;
        step();
        timer_over = 1'b0;
        step();
        check(status == 8'h01, "R8 timer sets bit0", status, 8'h01);
        rd_en = 1'b1; rd_addr = HIT;
        step();
        rd_en = 1'b0;
        check(status == 8'h00, "R8 timer bit cleared", status, 8'h00);
        timer_mode = 1'b0; timer_over = 1'b1;
        step();
        step();
        check(status == 8'h00, "R8 timer ignored in limit mode", status, 8'h00);
        timer_over = 1'b0;

        // R10: stray-address read and idle hold.
        lim_hi = 7'h48;
        step();
        lim_hi = '0;
        rd_en = 1'b1; rd_addr = HIT;
        lim_lo = 7'h40;
        step();
        lim_lo = '0;
        rd_en = 1'b1; rd_addr = MISS;
        step();
        rd_en = 1'b0;
        check(status == 8'h40, "R10 miss clears nothing", status, 8'h40);
        check(rd_data == 8'h00, "R10 miss returns zero", rd_data, 8'h00);
        rd_en = 1'b1; rd_addr = HIT;
        step();
        rd_en = 1'b0;
        check(rd_data == 8'h40, "R6 R10 hit after miss", rd_data, 8'h40);
        step();
        step();
        check(rd_data == 8'h40, "R10 idle hold", rd_data, 8'h40);
        check(status == 8'h00, "R4 final clear", status, 8'h00);

        finish_run();
    end

endmodule